// File: doc/BRIEF.md
# DMA Source Address Counter

This unit keeps the source address of one DMA channel whose transfers are confined to a single 64 KB internal window. Software writes the low 16 address bits through a halfword register port. The unit always drives a full 32-bit source address, and the upper half of that address is fixed at 0x0080. Reads return the live running value. There is no separate reload copy.

The channel control logic sends the unit a strobe for each completed transfer, a mode select and a size select. In fixed mode the address holds. In incrementing mode it advances by 1 after each 8-bit transfer and by 2 after each 16-bit transfer, and it wraps within the low half. When the channel's transfer count underflows, the address freezes until software writes a new start value. Any write that does not drive both byte lanes is flagged as an access error. The unit ignores such a write.

Top module: `src_addr_unit`

## Requirements
- R1: `src_addr[31:16]` is always 0x0080 and `src_addr[15:0]` always equals `rd_data`. `rd_data` bit 15 is the most significant low address bit and bit 0 is the least significant.
- R2: A write with `wr_en`=1 and `wr_be`=2'b11 loads `wr_data`. The new value is visible on `rd_data` and `src_addr` after the next clock edge.
- R3: With `mode_inc`=0 (fixed mode), a `xfer_stb` pulse leaves the address unchanged.
- R4: With `mode_inc`=1 and `size_16`=0, each `xfer_stb` pulse adds 1 to the address.
- R5: With `mode_inc`=1 and `size_16`=1, each `xfer_stb` pulse adds 2 to the address. An odd start value is not corrected and stays odd.
- R6: Increments wrap modulo 2^16 inside the low half. For example, 0xFFFF+1 gives 0x0000 and 0xFFFE+2 gives 0x0000, and the upper half is unaffected.
- R7: When a full halfword write and a `xfer_stb` pulse fall in the same cycle, the written value is loaded and the step is discarded.
- R8: `cnt_underflow`=1 freezes the address. A step requested in that same cycle still applies. Later `xfer_stb` pulses have no effect until the next full halfword write, after which stepping resumes.
- R9: A write with `wr_en`=1 and `wr_be` not equal to 2'b11 leaves the address unchanged. It also raises `acc_err` for exactly the following cycle.
- R10: After synchronous reset, `acc_err` is 0 and the freeze state from R8 is cleared. The address value itself is undefined until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_data | input | 16 | Write data for the low address half |
| wr_be | input | 2 | Byte-lane strobes; 2'b11 is the only legal pattern |
| xfer_stb | input | 1 | One-cycle pulse per completed transfer |
| mode_inc | input | 1 | 0 = fixed address, 1 = incrementing |
| size_16 | input | 1 | 0 = 8-bit transfers (step 1), 1 = 16-bit transfers (step 2) |
| cnt_underflow | input | 1 | Transfer count underflow; ends the run |
| rd_data | output | 16 | Live low address half |
| src_addr | output | 32 | Full source address, upper half 0x0080 |
| acc_err | output | 1 | One-cycle flag after a write that is not a full halfword |

## Verification
Two pairs of functions can land in the same cycle, and each is provoked on purpose.

- **Write and step:** a software write can collide with a transfer step. The bench drives a full halfword write and an incrementing 16-bit strobe on the same edge, then expects exactly the written value.
- **Last step and underflow:** the final step of a run can coincide with the underflow indication. The bench pulses the strobe and underflow together, expects the step to have applied, and then confirms that further strobes leave the address frozen until a rewrite.

// File: rtl/src_addr_pkg.sv
// Package: shared types for the DMA source address counter.
// Assumes: the step mode and transfer size are single-bit selects.
package src_addr_pkg;

    typedef enum logic {
        ADDR_FIXED = 1'b0,
        ADDR_STEP  = 1'b1
    } addr_mode_e;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_HALF = 1'b1
    } xfer_size_e;

endpackage

// File: rtl/sa_lane_check.sv
// Module: sa_lane_check
// Classifies a register write as a legal full-width access or a
// faulty partial one. Assumes one strobe bit per byte lane.
module sa_lane_check #(
    parameter int BE_W = 2
) (
    input  logic            wr_en,
    input  logic [BE_W-1:0] wr_be,
    output logic            wr_full,
    output logic            wr_bad
);

    logic [BE_W:0] all_lanes;

    assign all_lanes[0] = 1'b1;

    // Chain the lane strobes: all must be set for a legal access.
    generate
        for (genvar g = 0; g < BE_W; g++) begin : g_lane
            assign all_lanes[g+1] = all_lanes[g] & wr_be[g];
        end
    endgenerate

    // Split the write request into legal and faulty accesses.
    always_comb begin
        wr_full = wr_en & all_lanes[BE_W];
        wr_bad  = wr_en & ~all_lanes[BE_W];
    end

endmodule

// File: rtl/sa_step_calc.sv
// Module: sa_step_calc
// Computes the next running address for one transfer step.
// Assumes modulo 2^LOW_W wrap and no alignment correction.
module sa_step_calc
    import src_addr_pkg::*;
#(
    parameter int LOW_W       = 16,
    parameter int NARROW_STEP = 1,
    parameter int WIDE_STEP   = 2
) (
    input  logic [LOW_W-1:0] cur_addr,
    input  xfer_size_e       size_sel,
    output logic [LOW_W-1:0] next_addr
);

    localparam logic [LOW_W-1:0] NARROW_INC = LOW_W'(NARROW_STEP);
    localparam logic [LOW_W-1:0] WIDE_INC   = LOW_W'(WIDE_STEP);

    // Add the step selected by the transfer size; carry out is dropped.
    always_comb begin
        if (size_sel == XFER_HALF) next_addr = cur_addr + WIDE_INC;
        else                       next_addr = cur_addr + NARROW_INC;
    end

endmodule

// File: rtl/src_addr_unit.sv
// Module: src_addr_unit
// Per-channel source address counter for a DMA channel limited to one
// 2^LOW_W byte window. Holds the low address half as a live register,
// emits it with a fixed upper half, steps it per transfer, freezes on
// transfer count underflow and flags non-halfword writes.
// Assumes: xfer_stb is a one-cycle pulse per transfer; the register
// content is undefined after reset until software writes it.
module src_addr_unit
    import src_addr_pkg::*;
#(
    parameter int              LOW_W    = 16,
    parameter logic [LOW_W-1:0] UPPER_HI = 16'h0080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LOW_W-1:0]   wr_data,
    input  logic [LOW_W/8-1:0] wr_be,
    input  logic               xfer_stb,
    input  logic               mode_inc,
    input  logic               size_16,
    input  logic               cnt_underflow,
    output logic [LOW_W-1:0]   rd_data,
    output logic [2*LOW_W-1:0] src_addr,
    output logic               acc_err
);

    localparam int BE_W = LOW_W / 8;

    logic [LOW_W-1:0] cur_q;
    logic [LOW_W-1:0] step_val;
    logic             halted_q;
    logic             acc_err_q;
    logic             wr_full;
    logic             wr_bad;
    logic             do_step;
    addr_mode_e       mode_sel;
    xfer_size_e       size_sel;

    assign mode_sel = addr_mode_e'(mode_inc);
    assign size_sel = xfer_size_e'(size_16);

    sa_lane_check #(.BE_W(BE_W)) u_lane (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_full (wr_full),
        .wr_bad  (wr_bad)
    );

    sa_step_calc #(.LOW_W(LOW_W)) u_step (
        .cur_addr  (cur_q),
        .size_sel  (size_sel),
        .next_addr (step_val)
    );

    // Decide whether this cycle's strobe advances the address.
    always_comb begin
        do_step = xfer_stb & (mode_sel == ADDR_STEP) & ~halted_q;
    end

    // Live address register: a full write wins, otherwise step if allowed.
    always_ff @(posedge clk) begin
        if (wr_full)      cur_q <= wr_data;
        else if (do_step) cur_q <= step_val;
    end

    // Freeze state: set by underflow, cleared by a fresh full write.
    always_ff @(posedge clk) begin
        if (!rst_n)             halted_q <= 1'b0;
        else if (wr_full)       halted_q <= 1'b0;
        else if (cnt_underflow) halted_q <= 1'b1;
    end

    // Access error flag: one cycle after any partial-lane write.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_err_q <= 1'b0;
        else        acc_err_q <= wr_bad;
    end

    // Drive outputs from the live register and the fixed upper half.
    always_comb begin
        rd_data  = cur_q;
        src_addr = {UPPER_HI, cur_q};
        acc_err  = acc_err_q;
    end

endmodule

// File: rtl/src_addr_unit_chk.sv
// Module: src_addr_unit_chk
// Temporal checks on src_addr_unit, attached by bind. Assumes default
// 16-bit low half and a two-lane write port.
module src_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [1:0]  wr_be,
    input logic        xfer_stb,
    input logic        mode_inc,
    input logic        size_16,
    input logic        cnt_underflow,
    input logic [15:0] rd_data,
    input logic [31:0] src_addr,
    input logic        acc_err,
    input logic        halted_q
);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b11) |=> (rd_data == $past(wr_data)));

    assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !mode_inc && !wr_en) |=> $stable(src_addr));

    assert_step_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && mode_inc && !size_16 && !wr_en && !halted_q)
        |=> (rd_data == $past(rd_data) + 16'd1));

    // R5 / R6: the 16-bit step wraps inside the low half.
    assert_step_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && mode_inc && size_16 && !wr_en && !halted_q)
        |=> (rd_data == $past(rd_data) + 16'd2));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !wr_en) |=> $stable(rd_data));

    assert_bad_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be != 2'b11 && !xfer_stb) |=> (acc_err && $stable(rd_data)));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_be != 2'b11) |=> !acc_err);

    assert_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_addr[31:16] == 16'h0080));

endmodule

bind src_addr_unit src_addr_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .wr_be         (wr_be),
    .xfer_stb      (xfer_stb),
    .mode_inc      (mode_inc),
    .size_16       (size_16),
    .cnt_underflow (cnt_underflow),
    .rd_data       (rd_data),
    .src_addr      (src_addr),
    .acc_err       (acc_err),
    .halted_q      (halted_q)
);

// File: tb/tb_src_addr_unit.sv
// Directed bench for src_addr_unit: one task per scenario.
module tb_src_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [1:0]  wr_be;
    logic        xfer_stb;
    logic        mode_inc;
    logic        size_16;
    logic        cnt_underflow;
    logic [15:0] rd_data;
    logic [31:0] src_addr;
    logic        acc_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    src_addr_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_be         (wr_be),
        .xfer_stb      (xfer_stb),
        .mode_inc      (mode_inc),
        .size_16       (size_16),
        .cnt_underflow (cnt_underflow),
        .rd_data       (rd_data),
        .src_addr      (src_addr),
        .acc_err       (acc_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle with the given inputs, then back to idle.
    task automatic cyc(bit we, logic [15:0] d, logic [1:0] be, bit stb,
                       bit inc, bit s16, bit uf);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_be = be; xfer_stb = stb;
        mode_inc = inc; size_16 = s16; cnt_underflow = uf;
        @(posedge clk);
        #1;
        wr_en = 1'b0; xfer_stb = 1'b0; cnt_underflow = 1'b0; wr_be = 2'b00;
    endtask

    task automatic wr(logic [15:0] d);
        cyc(1'b1, d, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        check("R10 acc_err after reset", {31'd0, acc_err}, 32'd0);
        check("R1 upper half", {16'd0, src_addr[31:16]}, 32'h0080);
    endtask

    task automatic t_write();
        wr(16'h1234);
        check("R2 load", {16'd0, rd_data}, 32'h1234);
        check("R1 full address", src_addr, 32'h0080_1234);
    endtask

    task automatic t_fixed();
        wr(16'h1234);
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R3 fixed hold", {16'd0, rd_data}, 32'h1234);
    endtask

    task automatic t_inc8();
        wr(16'h0010);
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 byte step", {16'd0, rd_data}, 32'h0013);
    endtask

    task automatic t_inc16_odd();
        wr(16'h0101);
        for (int i = 0; i < 2; i++) cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R5 half step odd start", src_addr, 32'h0080_0105);
    endtask

    task automatic t_wrap();
        wr(16'hFFFF);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 byte wrap", src_addr, 32'h0080_0000);
        wr(16'hFFFE);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R6 half wrap", src_addr, 32'h0080_0000);
    endtask

    task automatic t_collide();
        wr(16'h3FF0);
        cyc(1'b1, 16'h4000, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R7 write beats step", {16'd0, rd_data}, 32'h4000);
    endtask

    task automatic t_underflow();
        wr(16'h0200);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8 last step applies", {16'd0, rd_data}, 32'h0204);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 frozen after underflow", {16'd0, rd_data}, 32'h0204);
        wr(16'h0300);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R8 resumes after rewrite", {16'd0, rd_data}, 32'h0302);
        cyc(1'b0, 16'h0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);
        cyc(1'b0, 16'h0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 underflow alone freezes", {16'd0, rd_data}, 32'h0302);
    endtask

    task automatic t_partial();
        wr(16'h0500);
        cyc(1'b1, 16'hAAAA, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 partial write ignored", {16'd0, rd_data}, 32'h0500);
        check("R9 acc_err raised", {31'd0, acc_err}, 32'd1);
        cyc(1'b0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 acc_err one cycle", {31'd0, acc_err}, 32'd0);
        cyc(1'b1, 16'h5555, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 upper lane write ignored", {16'd0, rd_data}, 32'h0500);
        check("R9 acc_err upper lane", {31'd0, acc_err}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_be = '0;
        xfer_stb = 1'b0; mode_inc = 1'b0; size_16 = 1'b0; cnt_underflow = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write();
        t_fixed();
        t_inc8();
        t_inc16_odd();
        t_wrap();
        t_collide();
        t_underflow();
        t_partial();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule